// File: doc/BRIEF.md
# Serial Receive Status Flag Unit

This block holds the receive-side status of an asynchronous serial receiver that also listens for a returned error signal, as used on smart-card links. A receiver datapath reports each finished character with a one-cycle completion pulse, the received byte and a parity-mismatch qualifier. It also pulses a separate input whenever the returned error line is sampled low. The block keeps the last accepted byte in a receive-data register. It maintains a data-full flag and three error flags: overrun, parity and error-signal.

Software reaches the block through a status read strobe, a status write strobe with write data, and a data read strobe. Error flags follow a two-step clear: software must first read the flag as 1 and then write 0 to that bit. While an overrun or a parity error is pending, the block refuses further characters. It raises a blocking output for the receiver, and a second one for the transmitter when the link runs in clocked synchronous mode.

Top module: `rxs_status_unit`

## Requirements
- R1: After reset, stat_o and rdata_o are 0, and rx_block_o and tx_block_o are low.
- R2: An accepted completion with parity good and the data-full flag (stat_o bit 6) at 0 stores rx_data_i into rdata_o and sets bit 6. Both changes are visible in the cycle after the pulse.
- R3: A data_rd_i pulse clears bit 6 in the next cycle. If a completion arrives in the same cycle as the read, the new byte is stored, bit 6 stays 1 and no overrun is flagged.
- R4: A completion while bit 6 is 1 and no data read occurs sets the overrun flag (stat_o bit 5). rdata_o keeps the earlier byte, the new byte is dropped and the parity flag is not touched.
- R5: A completion with parity_err_i high while bit 6 is 0 sets the parity flag (stat_o bit 3). The byte is still written to rdata_o and bit 6 stays 0.
- R6: While bit 5 or bit 3 is 1, completions change neither rdata_o, bit 6 nor any flag, and rx_block_o is high. tx_block_o is high under the same condition only when sync_mode_i is 1.
- R7: An err_sig_low_i pulse sets the error-signal flag (stat_o bit 4), whatever the state of rx_en_i.
- R8: A status read that sees an error flag at 1 arms its clear. The next status write with that bit at 0 clears the flag. A write with that bit at 1 leaves the flag at 1 and the clear still armed.
- R9: A status write of 0 to an error flag that was not read as 1 beforehand leaves the flag at 1.
- R10: If an error flag's set condition recurs between the arming read and the write of 0, that write leaves the flag at 1.
- R11: With rx_en_i low, completions are ignored: rdata_o, bit 6, bit 5 and bit 3 keep their values.
- R12: Bits 7, 2, 1 and 0 of stat_o always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| sync_mode_i | input | 1 | 1 selects clocked synchronous mode |
| rx_done_i | input | 1 | One-cycle pulse: a character was received |
| rx_data_i | input | DATA_W | Received byte, valid with rx_done_i |
| parity_err_i | input | 1 | Parity mismatch on this character, valid with rx_done_i |
| err_sig_low_i | input | 1 | Pulse: returned error line sampled low |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| wdata_i | input | 8 | Status write data |
| data_rd_i | input | 1 | Receive-data register read strobe |
| stat_o | output | 8 | Status register: bit 6 data full, bit 5 overrun, bit 4 error signal, bit 3 parity |
| rdata_o | output | DATA_W | Receive-data register |
| rx_block_o | output | 1 | Reception inhibited |
| tx_block_o | output | 1 | Transmission inhibited (synchronous mode) |

## Verification
The bench targets the same-cycle collisions. A data read that meets a completion must not produce an overrun; a design that checks the old full flag would raise one. A flag set that lands between the arming read and the clearing write must cancel the clear; a design that ignores it would lose a new error. Other tests write 0 without a prior read, write 1 after a read, and send completions while blocked or disabled. Those tests catch a flag that clears too easily, an arm that is consumed wrongly, and stored data or a set flag during a freeze. The parity path checks that the byte lands while the full flag stays 0.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned RDRF_BIT = 6;

  typedef enum int unsigned {
    FL_PERR = 0,
    FL_ESIG = 1,
    FL_OVR  = 2
  } flag_e;

  // error flags occupy contiguous status bits starting at 3
  function automatic int unsigned flag_bit(int unsigned idx);
    return 3 + idx;
  endfunction
endpackage

// File: rtl/rxs_err_flag.sv
module rxs_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic clr_req;

  assign clr_req = wr_i && !wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                  flag_q <= 1'b1;
      else if (clr_req && arm_q)  flag_q <= 1'b0;

      if (set_i)                  arm_q <= 1'b0;  // re-set cancels pending clear
      else if (clr_req)           arm_q <= 1'b0;
      else if (rd_i && flag_q)    arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rxs_rx_path.sv
module rxs_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              blk_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              parity_err_i,
  input  logic              data_rd_i,
  output logic              rdrf_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovr_set_o,
  output logic              perr_set_o
);
  logic              rdrf_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, still_full, store;

  assign accept     = rx_done_i && rx_en_i && !blk_i;
  assign still_full = rdrf_q && !data_rd_i;
  assign store      = accept && !still_full;
  assign ovr_set_o  = accept && still_full;
  assign perr_set_o = store && parity_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdrf_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (store) rdata_q <= rx_data_i;
      if (store && !parity_err_i) rdrf_q <= 1'b1;
      else if (data_rd_i)         rdrf_q <= 1'b0;
    end
  end

  assign rdrf_o  = rdrf_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/rxs_status_unit.sv
module rxs_status_unit
  import rxs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              sync_mode_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              parity_err_i,
  input  logic              err_sig_low_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              data_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rx_block_o,
  output logic              tx_block_o
);
  logic [FLAG_N-1:0] flag_set, flags;
  logic              rdrf, blk;

  assign blk = flags[FL_OVR] || flags[FL_PERR];

  rxs_rx_path #(.DATA_W(DATA_W)) u_rx_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en_i),
    .blk_i       (blk),
    .rx_done_i   (rx_done_i),
    .rx_data_i   (rx_data_i),
    .parity_err_i(parity_err_i),
    .data_rd_i   (data_rd_i),
    .rdrf_o      (rdrf),
    .rdata_o     (rdata_o),
    .ovr_set_o   (flag_set[FL_OVR]),
    .perr_set_o  (flag_set[FL_PERR])
  );

  assign flag_set[FL_ESIG] = err_sig_low_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    rxs_err_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[g]),
      .rd_i  (stat_rd_i),
      .wr_i  (stat_wr_i),
      .wbit_i(wdata_i[flag_bit(g)]),
      .flag_o(flags[g])
    );
  end

  always_comb begin
    stat_o = '0;
    stat_o[RDRF_BIT] = rdrf;
    for (int i = 0; i < FLAG_N; i++) stat_o[flag_bit(i)] = flags[i];
  end

  assign rx_block_o = blk;
  assign tx_block_o = blk && sync_mode_i;
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              sync_mode_i,
  input logic              rx_done_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              parity_err_i,
  input logic              err_sig_low_i,
  input logic              stat_wr_i,
  input logic [7:0]        wdata_i,
  input logic              data_rd_i,
  input logic [7:0]        stat_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rx_block_o,
  input logic              tx_block_o
);
  logic busy;
  assign busy = stat_o[5] || stat_o[3];

  assert_overrun_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_en_i && !busy && stat_o[6] && !data_rd_i) |=> (stat_o[5] && $stable(rdata_o)));

  assert_read_collision_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_en_i && !busy && !parity_err_i && data_rd_i) |=> (stat_o[6] && !stat_o[5]));

  assert_parity_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rx_en_i && !busy && parity_err_i && !stat_o[6])
      |=> (stat_o[3] && !stat_o[6] && rdata_o == $past(rx_data_i)));

  assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !stat_wr_i) |=> $stable(rdata_o));

  assert_tx_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_block_o |-> (rx_block_o && sync_mode_i));

  assert_esig_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sig_low_i |=> stat_o[4]);

  assert_write_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[5] && stat_wr_i && wdata_i[5]) |=> stat_o[5]);

  assert_clear_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[5]) |-> ($past(stat_wr_i) && !$past(wdata_i[5])));

  assert_disabled_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !stat_wr_i) |=> ($stable(stat_o[5]) && $stable(stat_o[3])));

  assert_unused_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[7] == 1'b0 && stat_o[2:0] == 3'b000));
endmodule

bind rxs_status_unit rxs_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .sync_mode_i  (sync_mode_i),
  .rx_done_i    (rx_done_i),
  .rx_data_i    (rx_data_i),
  .parity_err_i (parity_err_i),
  .err_sig_low_i(err_sig_low_i),
  .stat_wr_i    (stat_wr_i),
  .wdata_i      (wdata_i),
  .data_rd_i    (data_rd_i),
  .stat_o       (stat_o),
  .rdata_o      (rdata_o),
  .rx_block_o   (rx_block_o),
  .tx_block_o   (tx_block_o)
);

// File: tb/tb_rxs_status_unit.sv
module tb_rxs_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b1, sync_mode_i = 1'b0;
  logic       rx_done_i = 1'b0, parity_err_i = 1'b0, err_sig_low_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       stat_rd_i = 1'b0, stat_wr_i = 1'b0, data_rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] stat_o, rdata_o;
  logic       rx_block_o, tx_block_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  rxs_status_unit #(.DATA_W(8)) dut (.*);

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; rx_en_i = 1'b1; sync_mode_i = 1'b0;
    repeat (2) step();
    rst_ni = 1'b1; step();
  endtask

  task automatic rx(logic [7:0] d, logic p);
    rx_done_i = 1'b1; rx_data_i = d; parity_err_i = p;
    step();
    rx_done_i = 1'b0; parity_err_i = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
  endtask

  task automatic wr_stat(logic [7:0] v);
    stat_wr_i = 1'b1; wdata_i = v; step(); stat_wr_i = 1'b0;
  endtask

  task automatic rd_data();
    data_rd_i = 1'b1; step(); data_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 stat", stat_o, 0);
    chk("R1 rdata", rdata_o, 0);
    chk("R1 blocks", {rx_block_o, tx_block_o}, 0);
  endtask

  task automatic t_normal();
    do_reset();
    rx(8'hA5, 1'b0);
    chk("R2 rdata", rdata_o, 8'hA5);
    chk("R2 rdrf", stat_o, 8'h40);
    rd_data();
    chk("R3 rdrf clear", stat_o, 8'h00);
    rx(8'h3C, 1'b0);
    chk("R2 second byte", rdata_o, 8'h3C);
  endtask

  task automatic t_collision();
    do_reset();
    rx(8'h11, 1'b0);
    rx_done_i = 1'b1; rx_data_i = 8'h22; data_rd_i = 1'b1;
    step();
    rx_done_i = 1'b0; data_rd_i = 1'b0;
    chk("R3 completion wins stat", stat_o, 8'h40);
    chk("R3 completion wins data", rdata_o, 8'h22);
  endtask

  task automatic t_overrun();
    do_reset();
    rx(8'h55, 1'b0);
    rx(8'h66, 1'b1);
    chk("R4 overrun stat", stat_o, 8'h60);
    chk("R4 data kept", rdata_o, 8'h55);
  endtask

  task automatic t_parity();
    do_reset();
    rx(8'h77, 1'b1);
    chk("R5 parity stat", stat_o, 8'h08);
    chk("R5 data stored", rdata_o, 8'h77);
  endtask

  task automatic t_block();
    do_reset();
    rx(8'h01, 1'b1);
    chk("R6 rx_block", rx_block_o, 1);
    chk("R6 tx_block async", tx_block_o, 0);
    sync_mode_i = 1'b1; step();
    chk("R6 tx_block sync", tx_block_o, 1);
    rx(8'h02, 1'b0);
    chk("R6 frozen data", rdata_o, 8'h01);
    chk("R6 frozen stat", stat_o, 8'h08);
    rd_stat(); wr_stat(8'h00);
    chk("R6 unblocked", {rx_block_o, tx_block_o}, 0);
    rx(8'h03, 1'b0);
    chk("R6 accepts again", rdata_o, 8'h03);
  endtask

  task automatic t_esig();
    do_reset();
    rx_en_i = 1'b0;
    err_sig_low_i = 1'b1; step(); err_sig_low_i = 1'b0;
    chk("R7 esig set", stat_o, 8'h10);
    chk("R7 no block", rx_block_o, 0);
  endtask

  task automatic t_clear();
    do_reset();
    rx(8'h10, 1'b0); rx(8'h20, 1'b0);
    rd_stat();
    wr_stat(8'hFF);
    chk("R8 write one keeps", stat_o[5], 1);
    wr_stat(8'h00);
    chk("R8 cleared", stat_o[5], 0);
    chk("R8 rdrf untouched", stat_o[6], 1);
  endtask

  task automatic t_noarm();
    do_reset();
    err_sig_low_i = 1'b1; step(); err_sig_low_i = 1'b0;
    wr_stat(8'h00);
    chk("R9 no arm keeps", stat_o[4], 1);
    rd_stat(); wr_stat(8'h00);
    chk("R9 armed clears", stat_o[4], 0);
  endtask

  task automatic t_race();
    do_reset();
    err_sig_low_i = 1'b1; step(); err_sig_low_i = 1'b0;
    rd_stat();
    err_sig_low_i = 1'b1; step(); err_sig_low_i = 1'b0;
    wr_stat(8'h00);
    chk("R10 reset between keeps", stat_o[4], 1);
  endtask

  task automatic t_disabled();
    do_reset();
    rx(8'h44, 1'b1);
    rx_en_i = 1'b0;
    rx(8'h99, 1'b0);
    chk("R11 flags kept", stat_o, 8'h08);
    chk("R11 data kept", rdata_o, 8'h44);
    rd_stat(); wr_stat(8'h00);
    rx(8'h99, 1'b0);
    chk("R11 ignored while off", stat_o, 8'h00);
    chk("R11 data unchanged", rdata_o, 8'h44);
  endtask

  task automatic t_unused();
    do_reset();
    rx(8'h01, 1'b0); rx(8'h02, 1'b0);
    err_sig_low_i = 1'b1; step(); err_sig_low_i = 1'b0;
    chk("R12 unused bits", {stat_o[7], stat_o[2:0]}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_normal(); t_collision(); t_overrun(); t_parity();
        t_block(); t_esig(); t_clear(); t_noarm(); t_race();
        t_disabled(); t_unused();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule